// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

The sequencer decides which analog input a multichannel converter samples next. A host supplies a two-bit scan mode, a channel select value and a one-cycle start pulse. From these the block runs a sequence of conversions. For each conversion it drives a channel index and a one-cycle convert strobe. It then waits for a one-cycle done pulse from the converter before it moves on. A one-cycle end-of-sequence flag marks the completion.

There are four modes:
- an ascending scan from channel 0;
- a fixed-length burst on one channel;
- an ascending scan that starts at an upper start channel set by the channel count;
- a single conversion.

An external-clock option makes the burst and single modes run without limit until the host raises stop. Stop is honoured in every mode, once the conversion in flight has completed.

The channel count (4, 8 or 12) is a parameter. It sets the select width and the upper start channel. Mode and select are captured when a sequence starts, so the host may change them while the block is busy. The conversion handshake carries no data. It is a strobe/done pair and not a valid/ready stream. Back-pressure comes from the converter alone: no new strobe is issued until done arrives, however long that takes.

Top module: `scan_seq`

## Requirements
- R1: After reset, busy_o, conv_o and eos_o are low.
- R2: Mode 2'b00 converts channels 0, 1, ... up to and including the clamped select, one conversion each, in ascending order.
- R3: Mode 2'b01 converts the clamped selected channel REPEAT times (default 8) in a row, then ends, when ext_clk_i is low.
- R4: Mode 2'b10 converts in ascending order from the upper start channel up to the clamped select. The upper start channel is 2 when NUM_CH is 4, and 6 otherwise.
- R5: In mode 2'b10, a clamped select at or below the upper start channel gives exactly one conversion, of the upper start channel.
- R6: Mode 2'b11 converts the clamped selected channel exactly once when ext_clk_i is low.
- R7: With ext_clk_i high, modes 2'b01 and 2'b11 repeat the clamped selected channel until stop ends the sequence. Modes 2'b00 and 2'b10 are unaffected by ext_clk_i.
- R8: A select value at or above NUM_CH is treated as NUM_CH-1. The select width is 2 bits for NUM_CH of 4, and 4 bits otherwise.
- R9: conv_o is high for exactly one cycle per conversion. The first strobe comes in the cycle after an accepted start. Each later strobe comes in the cycle after the done pulse of the previous conversion. ch_o holds its value from the strobe until that conversion's done pulse.
- R10: stop_i seen high in any busy cycle, up to and including the cycle of a done pulse, ends the sequence at that done pulse.
- R11: busy_o rises in the cycle after an accepted start. It falls in the cycle after the last done pulse. eos_o is high in that same cycle only.
- R12: A start pulse while busy_o is high is ignored. Changes of mode_i and sel_i while busy do not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| mode_i | input | 2 | Scan mode, captured at start |
| sel_i | input | SEL_W | Channel select, captured at start |
| ext_clk_i | input | 1 | External-clock option, captured at start |
| stop_i | input | 1 | Host stop (not-acknowledge) request |
| done_i | input | 1 | Conversion-done pulse from the converter |
| conv_o | output | 1 | One-cycle convert strobe |
| ch_o | output | SEL_W | Channel index for the current conversion |
| busy_o | output | 1 | Sequence in progress |
| eos_o | output | 1 | One-cycle end-of-sequence flag |

## Verification
Two things can fall in the same cycle: a done pulse and a stop request, or a done pulse and a fresh start. The bench raises stop in the very cycle of a done pulse. It also raises stop several cycles earlier, and expects the same cut-off after that conversion in both cases. A start pulse with a different mode and select is injected while the sequencer waits for done. The bench then checks that the channel list and the conversion count match the original request exactly.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    MODE_FROM_ZERO = 2'b00,
    MODE_BURST     = 2'b01,
    MODE_UPPER     = 2'b10,
    MODE_SINGLE    = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    END_AT_LAST,
    END_AT_COUNT,
    END_ON_STOP
  } end_rule_e;

  function automatic int sel_width(input int n_ch);
    return (n_ch <= 4) ? 2 : 4;
  endfunction

  function automatic int upper_start(input int n_ch);
    return (n_ch <= 4) ? 2 : 6;
  endfunction

endpackage

// File: rtl/scan_plan.sv
module scan_plan
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 4
) (
  input  logic [1:0]      mode_i,
  input  logic [CH_W-1:0] sel_i,
  input  logic            ext_clk_i,
  output logic [CH_W-1:0] first_o,
  output logic [CH_W-1:0] last_o,
  output end_rule_e       rule_o
);
  localparam int TOP_CH = NUM_CH - 1;
  localparam int UP_CH  = upper_start(NUM_CH);

  logic [CH_W-1:0] clamped;

  always_comb begin
    if (sel_i > CH_W'(TOP_CH)) clamped = CH_W'(TOP_CH);
    else                       clamped = sel_i;
  end

  always_comb begin
    first_o = clamped;
    last_o  = clamped;
    rule_o  = END_AT_LAST;
    case (scan_mode_e'(mode_i))
      MODE_FROM_ZERO: begin
        first_o = '0;
      end
      MODE_BURST: begin
        rule_o = ext_clk_i ? END_ON_STOP : END_AT_COUNT;
      end
      MODE_UPPER: begin
        first_o = CH_W'(UP_CH);
        last_o  = (clamped > CH_W'(UP_CH)) ? clamped : CH_W'(UP_CH);
      end
      default: begin
        rule_o = ext_clk_i ? END_ON_STOP : END_AT_LAST;
      end
    endcase
  end
endmodule

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_seq_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int REPEAT = 8,
  parameter int CNT_W  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [CH_W-1:0] first_i,
  input  logic [CH_W-1:0] last_i,
  input  end_rule_e       rule_i,
  input  logic            stop_i,
  input  logic            done_i,
  output logic            conv_o,
  output logic [CH_W-1:0] ch_o,
  output logic            busy_o,
  output logic            eos_o
);
  seq_state_e      state_q;
  logic [CH_W-1:0] ch_q;
  logic [CH_W-1:0] last_q;
  end_rule_e       rule_q;
  logic [CNT_W-1:0] cnt_q;
  logic            stop_pend_q;
  logic            eos_q;
  logic            finish;

  always_comb begin
    finish = stop_pend_q | stop_i;
    case (rule_q)
      END_AT_LAST:  finish = finish | (ch_q == last_q);
      END_AT_COUNT: finish = finish | (cnt_q == CNT_W'(REPEAT - 1));
      default:      ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      ch_q        <= '0;
      last_q      <= '0;
      rule_q      <= END_AT_LAST;
      cnt_q       <= '0;
      stop_pend_q <= 1'b0;
      eos_q       <= 1'b0;
    end else begin
      eos_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_ISSUE;
            ch_q        <= first_i;
            last_q      <= last_i;
            rule_q      <= rule_i;
            cnt_q       <= '0;
            stop_pend_q <= 1'b0;
          end
        end
        ST_ISSUE: begin
          state_q     <= ST_WAIT;
          stop_pend_q <= stop_pend_q | stop_i;
        end
        default: begin
          stop_pend_q <= stop_pend_q | stop_i;
          if (done_i) begin
            if (finish) begin
              state_q <= ST_IDLE;
              eos_q   <= 1'b1;
            end else begin
              state_q <= ST_ISSUE;
              cnt_q   <= cnt_q + 1'b1;
              if (rule_q == END_AT_LAST) ch_q <= ch_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign conv_o = (state_q == ST_ISSUE);
  assign busy_o = (state_q != ST_IDLE);
  assign ch_o   = ch_q;
  assign eos_o  = eos_q;
endmodule

// File: rtl/scan_seq.sv
module scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int REPEAT = 8,
  localparam int SEL_W = sel_width(NUM_CH),
  localparam int CNT_W = $clog2(REPEAT + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_clk_i,
  input  logic             stop_i,
  input  logic             done_i,
  output logic             conv_o,
  output logic [SEL_W-1:0] ch_o,
  output logic             busy_o,
  output logic             eos_o
);
  logic [SEL_W-1:0] first_ch;
  logic [SEL_W-1:0] last_ch;
  end_rule_e        rule;

  scan_plan #(.NUM_CH(NUM_CH), .CH_W(SEL_W)) plan_i (
    .mode_i    (mode_i),
    .sel_i     (sel_i),
    .ext_clk_i (ext_clk_i),
    .first_o   (first_ch),
    .last_o    (last_ch),
    .rule_o    (rule)
  );

  scan_fsm #(.CH_W(SEL_W), .REPEAT(REPEAT), .CNT_W(CNT_W)) fsm_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .first_i (first_ch),
    .last_i  (last_ch),
    .rule_i  (rule),
    .stop_i  (stop_i),
    .done_i  (done_i),
    .conv_o  (conv_o),
    .ch_o    (ch_o),
    .busy_o  (busy_o),
    .eos_o   (eos_o)
  );
endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
  parameter int NUM_CH = 8,
  parameter int SEL_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic             done_i,
  input logic             conv_o,
  input logic [SEL_W-1:0] ch_o,
  input logic             busy_o,
  input logic             eos_o
);
  AST_CONV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |=> !conv_o); // R9
  AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |=> $stable(ch_o)); // R9
  AST_START_TO_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (conv_o && busy_o)); // R11
  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> (ch_o <= SEL_W'(NUM_CH - 1))); // R8
  AST_CONV_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_o |-> busy_o); // R11
  AST_EOS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    eos_o |-> (!busy_o && $past(busy_o))); // R11
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> busy_o); // R11
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_o && start_i && !done_i) |=> (busy_o && !conv_o)); // R12
  AST_STOP_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conv_o && stop_i && done_i) |=> (!busy_o && eos_o)); // R10
endmodule

bind scan_seq scan_seq_chk #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .stop_i  (stop_i),
  .done_i  (done_i),
  .conv_o  (conv_o),
  .ch_o    (ch_o),
  .busy_o  (busy_o),
  .eos_o   (eos_o)
);

// File: tb/scan_seq_tb_top.sv
module scan_seq_tb_top;
  localparam int NUM_CH = 8;
  localparam int REP    = 8;
  localparam int SW     = 4;
  localparam int UP     = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ext_i = 1'b0;
  logic done_i = 1'b0;
  logic stop_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [SW-1:0] sel_i = '0;
  logic conv_o, busy_o, eos_o;
  logic [SW-1:0] ch_o;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  scan_seq #(.NUM_CH(NUM_CH), .REPEAT(REP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .sel_i(sel_i),
    .ext_clk_i(ext_i), .stop_i(stop_i), .done_i(done_i), .conv_o(conv_o),
    .ch_o(ch_o), .busy_o(busy_o), .eos_o(eos_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void expect_seq(input int m, input int s, output int q[$]);
    int c;
    int hi;
    c = (s > NUM_CH - 1) ? NUM_CH - 1 : s;
    hi = (c > UP) ? c : UP;
    q.delete();
    case (m)
      0: for (int i = 0; i <= c; i++) q.push_back(i);
      1: for (int i = 0; i < REP; i++) q.push_back(c);
      2: for (int i = UP; i <= hi; i++) q.push_back(i);
      default: q.push_back(c);
    endcase
  endfunction

  // Runs one sequence; gap >= 1 idle cycles before each done pulse.
  task automatic run_seq(input string tag, input int m, input int s, input bit e,
                         input int stop_at, input int gap, input int poke_at,
                         output int got[$], output bit eos_seen);
    int guard;
    bit strobe_bad;
    bit busy_bad;
    guard = 0; strobe_bad = 0; busy_bad = 0;
    got.delete(); eos_seen = 0;
    @(negedge clk);
    mode_i = 2'(m); sel_i = SW'(s); ext_i = e; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (guard < 40) begin
      guard++;
      if (conv_o !== 1'b1) begin
        chk(tag, int'(conv_o), 1, "convert strobe present");
        break;
      end
      got.push_back(int'(ch_o));
      if (got.size() - 1 == stop_at && gap > 1) stop_i = 1'b1;
      for (int g = 0; g < gap; g++) begin
        if (g == 0 && got.size() - 1 == poke_at) begin
          start_i = 1'b1; mode_i = 2'b11; sel_i = '0; ext_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
        if (g < gap - 1) stop_i = stop_i & (gap > 1);
        if (conv_o !== 1'b0) strobe_bad = 1;
        if (busy_o !== 1'b1) busy_bad = 1;
      end
      if (got.size() - 1 == stop_at) stop_i = 1'b1;
      done_i = 1'b1;
      @(negedge clk);
      done_i = 1'b0; stop_i = 1'b0;
      if (busy_o !== 1'b1) begin
        eos_seen = eos_o;
        break;
      end
    end
    chk(tag, int'(strobe_bad), 0, "strobe low while waiting (R9)");
    chk(tag, int'(busy_bad), 0, "busy high while waiting (R11)");
    @(negedge clk);
    chk(tag, int'(eos_o), 0, "end flag lasts one cycle (R11)");
  endtask

  task automatic compare(input string tag, input int got[$], input int exp[$], input bit eos_seen);
    chk(tag, got.size(), exp.size(), "conversion count");
    foreach (exp[i])
      if (i < got.size()) chk(tag, got[i], exp[i], $sformatf("channel of conversion %0d", i));
    chk(tag, int'(eos_seen), 1, "end-of-sequence flag with busy fall");
  endtask

  task automatic t_reset();
    chk("R1", int'(busy_o), 0, "busy after reset");
    chk("R1", int'(conv_o), 0, "convert after reset");
    chk("R1", int'(eos_o), 0, "eos after reset");
  endtask

  task automatic t_from_zero();
    int got[$]; int exp[$]; bit eos;
    run_seq("R2", 0, 3, 0, -1, 2, -1, got, eos);
    expect_seq(0, 3, exp); compare("R2", got, exp, eos);
    run_seq("R2", 0, 0, 0, -1, 1, -1, got, eos);
    expect_seq(0, 0, exp); compare("R2", got, exp, eos);
    run_seq("R2", 0, 5, 1, -1, 3, -1, got, eos);
    expect_seq(0, 5, exp); compare("R7 ext scan", got, exp, eos);
  endtask

  task automatic t_burst();
    int got[$]; int exp[$]; bit eos;
    run_seq("R3", 1, 5, 0, -1, 1, -1, got, eos);
    expect_seq(1, 5, exp); compare("R3", got, exp, eos);
  endtask

  task automatic t_upper();
    int got[$]; int exp[$]; bit eos;
    run_seq("R4", 2, 7, 0, -1, 2, -1, got, eos);
    expect_seq(2, 7, exp); compare("R4", got, exp, eos);
    run_seq("R5", 2, 2, 0, -1, 1, -1, got, eos);
    expect_seq(2, 2, exp); compare("R5", got, exp, eos);
    run_seq("R5", 2, 6, 0, -1, 1, -1, got, eos);
    expect_seq(2, 6, exp); compare("R5", got, exp, eos);
  endtask

  task automatic t_single();
    int got[$]; int exp[$]; bit eos;
    run_seq("R6", 3, 4, 0, -1, 2, -1, got, eos);
    expect_seq(3, 4, exp); compare("R6", got, exp, eos);
  endtask

  task automatic t_clamp();
    int got[$]; int exp[$]; bit eos;
    run_seq("R8", 3, 13, 0, -1, 1, -1, got, eos);
    expect_seq(3, 7, exp); compare("R8", got, exp, eos);
    run_seq("R8", 0, 15, 0, -1, 1, -1, got, eos);
    expect_seq(0, 7, exp); compare("R8", got, exp, eos);
  endtask

  task automatic t_ext();
    int got[$]; int exp[$]; bit eos;
    run_seq("R7", 1, 3, 1, 11, 1, -1, got, eos);
    exp.delete(); for (int i = 0; i < 12; i++) exp.push_back(3);
    compare("R7", got, exp, eos);
    run_seq("R7", 3, 9, 1, 3, 2, -1, got, eos);
    exp.delete(); for (int i = 0; i < 4; i++) exp.push_back(7);
    compare("R7", got, exp, eos);
  endtask

  task automatic t_stop();
    int got[$]; int exp[$]; bit eos;
    run_seq("R10", 0, 7, 0, 2, 3, -1, got, eos);
    exp = '{0, 1, 2}; compare("R10 early stop", got, exp, eos);
    run_seq("R10", 1, 4, 0, 1, 1, -1, got, eos);
    exp = '{4, 4}; compare("R10 stop with done", got, exp, eos);
  endtask

  task automatic t_busy_start();
    int got[$]; int exp[$]; bit eos;
    run_seq("R12", 0, 3, 0, -1, 2, 1, got, eos);
    expect_seq(0, 3, exp); compare("R12", got, exp, eos);
  endtask

  initial begin
    #(200000 * 4);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_from_zero();
    t_burst();
    t_upper();
    t_single();
    t_clamp();
    t_ext();
    t_stop();
    t_busy_start();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule